// File: doc/BRIEF.md
# Prescaled Pseudo-Random Clock Generator

This block makes a spread-spectrum style clock from the system clock. A free-running power-of-two prescaler produces a one-cycle tick. Each tick advances a pair of maximal-length Fibonacci shift-register sequence generators, one 8 bits long and one 12 bits long. The pseudo-random output bit is the top bit of whichever generator is selected. A single 8-bit control register sets the divide code, prescaler bypass, sequence enable, sequence length, output inversion and pin routing. When routing is on, the pin output carries the generated clock, inverted if asked. When routing is off, the pin carries a default signal supplied on an input port.

A two-state machine governs the sequence generators. In state ST_IDLE the generators are held at their seeds. The transition IDLE_TO_RUN is taken on the first clock edge at which the enable bit is set. In state ST_RUN the generators step once per prescaler tick. The transition RUN_TO_IDLE is taken on the first edge at which the enable bit is clear, and that same edge reloads the seeds.

Top module: `prs_clkgen`

## Requirements
- R1: The control register resets to 0x00. A write with `ctrl_we` high stores `ctrl_wdata` at that clock edge, and the stored value appears on `ctrl_rdata_o` from the next cycle. Bit layout: [2:0] divide code, [3] bypass, [4] sequence enable, [5] length select, [6] invert, [7] route.
- R2: An 8-bit counter starts at 0 after reset and adds one every cycle. With bypass clear, `presc_tick_o` is high in exactly the cycles where the low (code+1) bits of that counter are all ones. This gives one tick every 2^(code+1) cycles, from 2 for code 0 up to 256 for code 7.
- R3: With bypass set, `presc_tick_o` is high in every cycle, whatever the divide code.
- R4: While the enable bit is clear, `prs_bit_o` is 0. The 8-bit generator is held at seed 0x01 and the 12-bit generator at seed 0x001.
- R5: In ST_RUN, both generators shift left by one bit on each clock edge at which a tick is present. The 8-bit generator's new bit 0 is the XOR of bits 7, 5, 4 and 3 (x^8+x^6+x^5+x^4+1). With the length bit clear, `prs_bit_o` is bit 7 of the 8-bit generator.
- R6: The 12-bit generator's new bit 0 is the XOR of bits 11, 5, 3 and 0 (x^12+x^6+x^4+x+1). With the length bit set, `prs_bit_o` is bit 11 of the 12-bit generator.
- R7: With route set, the routed clock is the pseudo-random bit when the enable bit is set, and the prescaler tick otherwise. `pin_clk_o` is that routed clock, inverted when the invert bit is 1 and unchanged when it is 0.
- R8: With route clear, `pin_clk_o` equals `dflt_out_i`, and the invert bit has no effect on it.
- R9: The machine moves from ST_IDLE to ST_RUN on the first edge at which the enable bit is set, and no step happens on that edge. It moves from ST_RUN back to ST_IDLE on the first edge at which the enable bit is clear, and that edge reloads the seeds. Re-enabling therefore restarts both sequences from their seeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata_o | output | 8 | Control register contents |
| dflt_out_i | input | 1 | Default pin signal used when routing is off |
| presc_tick_o | output | 1 | Prescaler tick (clock enable) |
| prs_bit_o | output | 1 | Pseudo-random sequence output bit |
| pin_clk_o | output | 1 | Final pin clock |

## Verification
The divide path is exercised with codes 0, 3 and 7. Each is run for long enough to see several ticks, so an off-by-one in the mask or in the counter phase shows up as a tick in the wrong cycle. Bypass is tried with a non-zero code, to separate "ignore the code" from "code 0".

The sequence path runs the 8-bit generator over more than a full 255-step period, then switches to the 12-bit length while running. Any wrong tap or wrong length select then diverges from the reference within a few steps. The sequence is also disabled and re-enabled mid-run to show the reseed.

A toggling default input is applied with routing both off and on, and with invert both set and clear. This tells pass-through apart from the routed clock and from its inverted form.

// File: rtl/prs_clkgen_pkg.sv
package prs_clkgen_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned CNT_W  = 1 << CODE_W;
    localparam int unsigned L8_W   = 8;
    localparam int unsigned L12_W  = 12;

    typedef struct packed {
        logic              route;
        logic              invert;
        logic              len12;
        logic              seq_en;
        logic              bypass;
        logic [CODE_W-1:0] div_code;
    } ctrl_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/prs_prescaler.sv
module prs_prescaler
    import prs_clkgen_pkg::*;
#(
    parameter int unsigned C_W = CODE_W,
    localparam int unsigned N_W = 1 << C_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [C_W-1:0] code,
    input  logic           bypass,
    output logic           tick
);

    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // mask holds code+1 low ones
    always_comb begin
        mask = {N_W{1'b1}} >> (N_W - 1 - int'(code));
        tick = bypass | ((cnt_q & mask) == mask);
    end

endmodule

// File: rtl/prs_lfsr.sv
module prs_lfsr #(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] q
);

    logic fb;

    assign fb = ^(q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= SEED;
        else if (load) q <= SEED;
        else if (step) q <= {q[W-2:0], fb};
    end

endmodule

// File: rtl/prs_seq_ctrl.sv
module prs_seq_ctrl
    import prs_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic load,
    output logic step,
    output logic running
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;   // IDLE_TO_RUN
            ST_RUN:  if (!enable) state_d = ST_IDLE;  // RUN_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: load = 1'b1;
            ST_RUN: begin
                running = 1'b1;
                load    = !enable;
                step    = enable & tick;
            end
            default: load = 1'b1;
        endcase
    end

endmodule

// File: rtl/prs_clkgen.sv
module prs_clkgen
    import prs_clkgen_pkg::*;
#(
    parameter logic [L8_W-1:0]  SEED8  = 8'h01,
    parameter logic [L12_W-1:0] SEED12 = 12'h001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    output logic [7:0] ctrl_rdata_o,
    input  logic       dflt_out_i,
    output logic       presc_tick_o,
    output logic       prs_bit_o,
    output logic       pin_clk_o
);

    localparam logic [L8_W-1:0]  TAPS8  = 8'hB8;   // bits 7,5,4,3
    localparam logic [L12_W-1:0] TAPS12 = 12'h829; // bits 11,5,3,0

    ctrl_t             ctrl_q;
    logic              tick;
    logic              load;
    logic              step;
    logic              running;
    logic [L8_W-1:0]   q8;
    logic [L12_W-1:0]  q12;
    logic              seq_bit;
    logic              routed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    prs_prescaler #(.C_W(CODE_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (ctrl_q.div_code),
        .bypass (ctrl_q.bypass),
        .tick   (tick)
    );

    prs_seq_ctrl u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_q.seq_en),
        .tick    (tick),
        .load    (load),
        .step    (step),
        .running (running)
    );

    prs_lfsr #(.W(L8_W), .TAPS(TAPS8), .SEED(SEED8)) u_lfsr8 (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .q     (q8)
    );

    prs_lfsr #(.W(L12_W), .TAPS(TAPS12), .SEED(SEED12)) u_lfsr12 (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .q     (q12)
    );

    always_comb begin
        seq_bit = 1'b0;
        if (ctrl_q.seq_en && running)
            seq_bit = ctrl_q.len12 ? q12[L12_W-1] : q8[L8_W-1];
        routed = ctrl_q.seq_en ? seq_bit : tick;
    end

    assign ctrl_rdata_o = ctrl_q;
    assign presc_tick_o = tick;
    assign prs_bit_o    = seq_bit;
    assign pin_clk_o    = ctrl_q.route ? (routed ^ ctrl_q.invert) : dflt_out_i;

endmodule

// File: rtl/prs_clkgen_chk.sv
module prs_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata_o,
    input logic       dflt_out_i,
    input logic       presc_tick_o,
    input logic       prs_bit_o,
    input logic       pin_clk_o
);

    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_rdata_o == $past(ctrl_wdata)));

    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_tick_o && !ctrl_we && !ctrl_rdata_o[3]) |=> !presc_tick_o);

    p_bypass_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata_o[3] |-> presc_tick_o);

    p_off_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata_o[4] |-> !prs_bit_o);

    p_inverted_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o[7] && ctrl_rdata_o[6] && !ctrl_rdata_o[4]) |-> (pin_clk_o == !presc_tick_o));

    p_default_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata_o[7] |-> (pin_clk_o == dflt_out_i));

endmodule

bind prs_clkgen prs_clkgen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (ctrl_we),
    .ctrl_wdata   (ctrl_wdata),
    .ctrl_rdata_o (ctrl_rdata_o),
    .dflt_out_i   (dflt_out_i),
    .presc_tick_o (presc_tick_o),
    .prs_bit_o    (prs_bit_o),
    .pin_clk_o    (pin_clk_o)
);

// File: tb/prs_clkgen_bench.sv
`timescale 1ns/1ps
module prs_clkgen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata_o;
    logic       dflt_out_i = 1'b0;
    logic       presc_tick_o;
    logic       prs_bit_o;
    logic       pin_clk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prs_clkgen u_prs_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .ctrl_rdata_o (ctrl_rdata_o),
        .dflt_out_i   (dflt_out_i),
        .presc_tick_o (presc_tick_o),
        .prs_bit_o    (prs_bit_o),
        .pin_clk_o    (pin_clk_o)
    );

    // reference model state
    int m_ctrl = 0;
    int m_cnt  = 0;
    int m_s8   = 1;
    int m_s12  = 1;
    bit m_run  = 1'b0;

    function automatic bit f_tick(int c, int cnt);
        int msk;
        if (c[3]) return 1'b1;
        msk = (2 << (c & 7)) - 1;
        return ((cnt % 256) & msk) == msk;
    endfunction

    function automatic int f_next8(int s);
        int b;
        b = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        return ((s << 1) & 255) | b;
    endfunction

    function automatic int f_next12(int s);
        int b;
        b = ((s >> 11) ^ (s >> 5) ^ (s >> 3) ^ s) & 1;
        return ((s << 1) & 4095) | b;
    endfunction

    function automatic bit f_prs();
        if (!m_ctrl[4] || !m_run) return 1'b0;
        return m_ctrl[5] ? m_s12[11] : m_s8[7];
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            bit tk;
            tk = f_tick(m_ctrl, m_cnt);
            if (!m_run) begin
                m_s8 = 1; m_s12 = 1;
                m_run = m_ctrl[4];
            end else if (!m_ctrl[4]) begin
                m_s8 = 1; m_s12 = 1;
                m_run = 1'b0;
            end else if (tk) begin
                m_s8  = f_next8(m_s8);
                m_s12 = f_next12(m_s12);
            end
            if (ctrl_we) m_ctrl = ctrl_wdata;
            m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit tk, rt, pe;
            tk = f_tick(m_ctrl, m_cnt);
            pe = f_prs();
            chk("R1 rdata", ctrl_rdata_o, m_ctrl);
            chk(m_ctrl[3] ? "R3 tick" : "R2 tick", presc_tick_o, tk);
            chk(m_ctrl[5] ? "R6 prs" : (m_ctrl[4] ? "R5 prs" : "R4 prs"), prs_bit_o, pe);
            rt = m_ctrl[4] ? pe : tk;
            if (m_ctrl[7]) chk("R7 pin", pin_clk_o, rt ^ m_ctrl[6]);
            else           chk("R8 pin", pin_clk_o, dflt_out_i);
        end
    end

    always @(posedge clk) if (!done) dflt_out_i <= #2 $urandom_range(0, 1);

    task automatic wr(logic [7:0] v);
        @(posedge clk); #2;
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(posedge clk); #2;
        ctrl_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #1;
        chk("R1 reset rdata", ctrl_rdata_o, 0);
        chk("R4 reset prs", prs_bit_o, 0);
        chk("R2 reset tick", presc_tick_o, 0);
        #12 rst_n = 1'b1;
        idle(6);
        wr(8'h00); idle(20);            // R2 code 0
        wr(8'h03); idle(70);            // R2 code 3
        wr(8'h07); idle(600);           // R2 code 7
        wr(8'h0D); idle(30);            // R3 bypass ignores code
        wr(8'hC2); idle(40);            // R7 inverted tick on pin
        wr(8'h10); idle(600);           // R5 8-bit sequence, full period
        wr(8'h30); idle(400);           // R6 12-bit
        wr(8'h00); idle(5);             // R9 disable
        wr(8'h11); idle(200);           // R9 reseed, R5 at code 1
        wr(8'h98); idle(100);           // R7 routed prs, bypass
        wr(8'hF8); idle(100);           // R7 inverted 12-bit
        wr(8'h58); idle(60);            // R8 invert has no effect
        @(negedge clk); #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule